// File: doc/BRIEF.md
# Catch-Word Erasure Corrector for a Nine-Chip Rank

This block sits on the read and write data path of a memory controller that drives a rank of eight data chips and one parity chip. On the way out to memory it generates the parity slice as the XOR of the eight data slices. On the way back it looks for chips that have flagged themselves. A chip whose internal error detection fires sends a fixed catch-word in place of its data. The block uses that in-band marker to find the faulty chip, so no extra signal or transfer is needed. Once it knows which chip failed, it treats that chip as an erasure and rebuilds the slice from the parity and the other seven data slices.

Each chip delivers a slice of `BEATS` beats of `BEAT_W` bits, which is 64 bits by default. Beat b of a slice occupies bits `[b*BEAT_W +: BEAT_W]`. Data slice i of the word occupies bits `[i*SLICE_W +: SLICE_W]`. The parity chip is numbered `NUM_DATA`. A parity check on the slices taken as received separates a real data value that happens to equal the catch-word from a chip alarm. Requests flow through a single registered stage with valid/ready on both sides.

Top module: `cw_erasure_ctrl`

## Requirements
- R1: A write request returns its data unchanged, with `out_parity` equal to the XOR of the `NUM_DATA` data slices, status CLEAN (0) and chip index 0.
- R2: A read whose nine slices XOR to zero returns data and parity unchanged, with status CLEAN (0) and chip index 0, even when some slices equal the catch-word.
- R3: A read that fails the parity check, where exactly one data slice k equals the catch-word and the parity slice does not, returns slice k replaced by the XOR of the parity slice and the other data slices. The status is CORRECTED_DATA (1) and the chip index is k. The parity and all other slices pass unchanged.
- R4: A read that fails the parity check, where only the parity slice equals the catch-word, returns the data unchanged with `out_parity` rebuilt as the XOR of the data slices. The status is CORRECTED_PARITY (2) and the chip index is `NUM_DATA`.
- R5: A read that fails the parity check with no slice equal to the catch-word returns data and parity unchanged, with status UNCORRECTABLE (3) and chip index 0.
- R6: A read that fails the parity check with two or more slices (parity included) equal to the catch-word returns data and parity unchanged, with status UNCORRECTABLE (3) and chip index 0.
- R7: A request accepted on a clock edge (`in_valid` and `in_ready` high) appears on the outputs with `out_valid` high right after that edge, one cycle of latency.
- R8: `in_ready` is high exactly when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R9: A synchronous active-high `rst` empties the stage, so `out_valid` is low after the edge, and `in_ready` is high once `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can take a request |
| in_write | input | 1 | 1 = write (generate parity), 0 = read (check and repair) |
| in_data | input | NUM_DATA*SLICE_W | Data slices, slice i at bits i*SLICE_W |
| in_parity | input | SLICE_W | Parity chip slice as read (ignored on writes) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | NUM_DATA*SLICE_W | Data slices after repair |
| out_parity | output | SLICE_W | Generated or repaired parity slice |
| out_status | output | 2 | 0 CLEAN, 1 CORRECTED_DATA, 2 CORRECTED_PARITY, 3 UNCORRECTABLE |
| out_chip | output | CHIP_W | Index of the repaired chip, 0 when nothing was repaired |

## Verification
The bench keeps the default geometry of eight data chips with eight-beat, eight-bit slices. It overrides the catch-word with a constant different from the default, so a marker value fixed in the logic would be caught. With eight data chips, every erasure position from 0 to 7 and the parity index 8 can be hit directly, as can pairs of flagged chips that include the parity chip. Random stalls on `out_ready` reach the hold and back-to-back paths of the single stage.

// File: rtl/cwe_pkg.sv
package cwe_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN        = 2'd0,
    ST_FIXED_DATA   = 2'd1,
    ST_FIXED_PARITY = 2'd2,
    ST_UNCORR       = 2'd3
  } cwe_status_e;
endpackage

// File: rtl/cwe_xor_tree.sv
// XOR reduction of N slices of W bits.
module cwe_xor_tree #(
  parameter int N = 8,
  parameter int W = 64
) (
  input  logic [N*W-1:0] slices_i,
  output logic [W-1:0]   xor_o
);
  always_comb begin
    xor_o = '0;
    for (int i = 0; i < N; i++) begin
      xor_o = xor_o ^ slices_i[i*W +: W];
    end
  end
endmodule

// File: rtl/cwe_match.sv
// Compares every chip slice with the catch-word and summarises the hits.
module cwe_match #(
  parameter int              N     = 9,
  parameter int              W     = 64,
  parameter logic [W-1:0]    CW    = '0,
  parameter int              IDX_W = 4
) (
  input  logic [N*W-1:0]   slices_i,
  output logic [N-1:0]     hit_o,
  output logic             any_o,
  output logic             multi_o,
  output logic [IDX_W-1:0] idx_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_o[g] = (slices_i[g*W +: W] == CW);
    end
  endgenerate

  // Descending scan: the lowest flagged index wins, a second hit sets multi.
  always_comb begin
    any_o   = 1'b0;
    multi_o = 1'b0;
    idx_o   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hit_o[i]) begin
        multi_o = multi_o | any_o;
        any_o   = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cwe_decide.sv
// Classifies a read and rebuilds the erased slice.
module cwe_decide
  import cwe_pkg::*;
#(
  parameter int NUM_DATA = 8,
  parameter int W        = 64,
  parameter int IDX_W    = 4
) (
  input  logic [NUM_DATA*W-1:0] data_i,
  input  logic [W-1:0]          parity_i,
  input  logic [NUM_DATA:0]     hit_i,
  input  logic                  any_i,
  input  logic                  multi_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [W-1:0]          data_xor_i,
  output logic [NUM_DATA*W-1:0] data_o,
  output logic [W-1:0]          parity_o,
  output cwe_status_e           status_o,
  output logic [IDX_W-1:0]      chip_o
);
  logic [W-1:0]          syndrome;
  logic [NUM_DATA*W-1:0] rebuilt;

  assign syndrome = data_xor_i ^ parity_i;

  // XOR with the syndrome cancels the slice itself, leaving parity ^ others.
  genvar g;
  generate
    for (g = 0; g < NUM_DATA; g++) begin : g_fix
      assign rebuilt[g*W +: W] = hit_i[g] ? (data_i[g*W +: W] ^ syndrome)
                                          : data_i[g*W +: W];
    end
  endgenerate

  always_comb begin
    data_o   = data_i;
    parity_o = parity_i;
    status_o = ST_CLEAN;
    chip_o   = '0;
    if (syndrome != '0) begin
      if (!any_i || multi_i) begin
        status_o = ST_UNCORR;
      end else if (hit_i[NUM_DATA]) begin
        status_o = ST_FIXED_PARITY;
        chip_o   = idx_i;
        parity_o = data_xor_i;
      end else begin
        status_o = ST_FIXED_DATA;
        chip_o   = idx_i;
        data_o   = rebuilt;
      end
    end
  end
endmodule

// File: rtl/cw_erasure_ctrl.sv
module cw_erasure_ctrl
  import cwe_pkg::*;
#(
  parameter int                      NUM_DATA   = 8,
  parameter int                      BEAT_W     = 8,
  parameter int                      BEATS      = 8,
  parameter logic [BEAT_W*BEATS-1:0] CATCH_WORD = 64'hC3A5_5A3C_F00D_0FF0,
  localparam int SLICE_W = BEAT_W*BEATS,
  localparam int DATA_W  = NUM_DATA*SLICE_W,
  localparam int CHIP_W  = $clog2(NUM_DATA+1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_write,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [SLICE_W-1:0] in_parity,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic [SLICE_W-1:0] out_parity,
  output logic [1:0]         out_status,
  output logic [CHIP_W-1:0]  out_chip
);
  logic [SLICE_W-1:0] data_xor;
  logic [NUM_DATA:0]  hit;
  logic               any_hit, multi_hit;
  logic [CHIP_W-1:0]  hit_idx;
  logic [DATA_W-1:0]  dec_data;
  logic [SLICE_W-1:0] dec_parity;
  cwe_status_e        dec_status;
  logic [CHIP_W-1:0]  dec_chip;

  cwe_xor_tree #(.N(NUM_DATA), .W(SLICE_W)) u_xor (
    .slices_i (in_data),
    .xor_o    (data_xor)
  );

  // Parity chip sits above the data slices, at index NUM_DATA.
  cwe_match #(.N(NUM_DATA+1), .W(SLICE_W), .CW(CATCH_WORD), .IDX_W(CHIP_W)) u_match (
    .slices_i ({in_parity, in_data}),
    .hit_o    (hit),
    .any_o    (any_hit),
    .multi_o  (multi_hit),
    .idx_o    (hit_idx)
  );

  cwe_decide #(.NUM_DATA(NUM_DATA), .W(SLICE_W), .IDX_W(CHIP_W)) u_dec (
    .data_i     (in_data),
    .parity_i   (in_parity),
    .hit_i      (hit),
    .any_i      (any_hit),
    .multi_i    (multi_hit),
    .idx_i      (hit_idx),
    .data_xor_i (data_xor),
    .data_o     (dec_data),
    .parity_o   (dec_parity),
    .status_o   (dec_status),
    .chip_o     (dec_chip)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  // Datapath registers carry no reset; they are qualified by out_valid.
  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_write ? in_data : dec_data;
      if (in_write) begin
        out_parity <= data_xor;
        out_status <= ST_CLEAN;
        out_chip   <= '0;
      end else begin
        out_parity <= dec_parity;
        out_status <= dec_status;
        out_chip   <= dec_chip;
      end
    end
  end
endmodule

// File: rtl/cwe_checker.sv
module cwe_checker
  import cwe_pkg::*;
#(
  parameter int NUM_DATA = 8,
  parameter int SLICE_W  = 64,
  parameter int CHIP_W   = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic                        in_write,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [NUM_DATA*SLICE_W-1:0] out_data,
  input logic [SLICE_W-1:0]          out_parity,
  input logic [1:0]                  out_status,
  input logic [CHIP_W-1:0]           out_chip
);
  logic [SLICE_W-1:0] out_xor;
  always_comb begin
    out_xor = '0;
    for (int i = 0; i < NUM_DATA; i++) out_xor = out_xor ^ out_data[i*SLICE_W +: SLICE_W];
  end

  p_reset_idle_r9: assert property (@(posedge clk) rst |=> !out_valid);

  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_parity)
                               && $stable(out_status) && $stable(out_chip));

  p_write_clean_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_write |=> out_status == ST_CLEAN && out_chip == '0);

  // Any result other than uncorrectable leaves a consistent stripe.
  p_consistent_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_status != ST_UNCORR |-> out_xor == out_parity);

  p_data_chip_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_status == ST_FIXED_DATA |-> out_chip < CHIP_W'(NUM_DATA));

  p_parity_chip_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_status == ST_FIXED_PARITY |-> out_chip == CHIP_W'(NUM_DATA));

  p_uncorr_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_status == ST_UNCORR |-> out_xor != out_parity && out_chip == '0);
endmodule

bind cw_erasure_ctrl cwe_checker #(
  .NUM_DATA (NUM_DATA),
  .SLICE_W  (SLICE_W),
  .CHIP_W   (CHIP_W)
) u_cwe_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_write   (in_write),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_parity (out_parity),
  .out_status (out_status),
  .out_chip   (out_chip)
);

// File: tb/test_cw_erasure_ctrl.sv
`timescale 1ns/1ps
module test_cw_erasure_ctrl;
  localparam int ND = 8;
  localparam int SW = 64;
  localparam int DW = ND*SW;
  localparam int CWB = 4;
  localparam logic [SW-1:0] CW = 64'h5A5A_0000_FFFF_A5A5;
  localparam int CYCLE_LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [DW-1:0] in_data = '0, out_data;
  logic [SW-1:0] in_parity = '0, out_parity;
  logic [1:0] out_status;
  logic [CWB-1:0] out_chip;
  bit bp_en = 1'b0;
  int n_chk = 0, n_err = 0;

  typedef struct {
    logic [DW-1:0]  data;
    logic [SW-1:0]  par;
    logic [1:0]     st;
    logic [CWB-1:0] chip;
    string          tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  cw_erasure_ctrl #(.NUM_DATA(ND), .BEAT_W(8), .BEATS(8), .CATCH_WORD(CW)) i_cw_erasure_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_data(in_data), .in_parity(in_parity), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_parity(out_parity), .out_status(out_status), .out_chip(out_chip)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] xor_of(input logic [DW-1:0] d);
    logic [SW-1:0] x = '0;
    for (int i = 0; i < ND; i++) x ^= d[i*SW +: SW];
    return x;
  endfunction

  // Reference model written from the requirements.
  function automatic exp_t model(input logic wr, input logic [DW-1:0] d, input logic [SW-1:0] p);
    exp_t e;
    int hits = 0, k = 0;
    logic [SW-1:0] s;
    e.data = d; e.par = p; e.st = 2'd0; e.chip = '0;
    if (wr) begin
      e.par = xor_of(d); e.tag = "R1";
      return e;
    end
    s = xor_of(d) ^ p;
    if (s == '0) begin e.tag = "R2"; return e; end
    for (int i = 0; i < ND; i++) if (d[i*SW +: SW] == CW) begin hits++; k = i; end
    if (p == CW) begin hits++; k = ND; end
    if (hits == 0) begin e.st = 2'd3; e.tag = "R5"; end
    else if (hits > 1) begin e.st = 2'd3; e.tag = "R6"; end
    else if (k == ND) begin e.st = 2'd2; e.chip = CWB'(ND); e.par = xor_of(d); e.tag = "R4"; end
    else begin
      e.st = 2'd1; e.chip = CWB'(k); e.tag = "R3";
      e.data[k*SW +: SW] = d[k*SW +: SW] ^ s;
    end
    return e;
  endfunction

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      q.delete();
    end else begin
      chk(out_valid === (q.size() > 0), "R7", "out_valid", DW'(out_valid), DW'(q.size() > 0));
      chk(in_ready === (q.size() == 0 || out_ready), "R8", "in_ready", DW'(in_ready),
          DW'(q.size() == 0 || out_ready));
      if (out_valid && q.size() > 0) begin
        chk(out_data === q[0].data, q[0].tag, "out_data", out_data, q[0].data);
        chk(out_parity === q[0].par, q[0].tag, "out_parity", DW'(out_parity), DW'(q[0].par));
        chk(out_status === q[0].st, q[0].tag, "out_status", DW'(out_status), DW'(q[0].st));
        chk(out_chip === q[0].chip, q[0].tag, "out_chip", DW'(out_chip), DW'(q[0].chip));
        if (out_ready) void'(q.pop_front());
      end
      if (in_valid && in_ready) q.push_back(model(in_write, in_data, in_parity));
    end
  end

  always @(posedge clk) begin
    #2;
    if (bp_en) out_ready = ($urandom_range(0, 2) != 0);
  end

  task automatic send(input logic wr, input logic [DW-1:0] d, input logic [SW-1:0] p);
    in_valid = 1'b1; in_write = wr; in_data = d; in_parity = p;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] rnd_data();
    logic [DW-1:0] d;
    for (int i = 0; i < DW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(CYCLE_LIMIT*10);
    n_err++;
    $display("FAIL R7 watchdog: run active after %0d cycles, expected completion", CYCLE_LIMIT);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid after reset", DW'(out_valid), '0);
    chk(in_ready === 1'b1, "R9", "in_ready after reset", DW'(in_ready), DW'(1));
    @(posedge clk); #2;

    // R1 writes, then R2 clean read-back of each
    for (int i = 0; i < 6; i++) begin
      d = rnd_data();
      send(1'b1, d, rnd_data()[SW-1:0]);
      send(1'b0, d, xor_of(d));
    end
    // R2 genuine data equal to the catch-word
    d = rnd_data(); d[3*SW +: SW] = CW;
    send(1'b0, d, xor_of(d));
    // R3 erasure on every data chip
    for (int k = 0; k < ND; k++) begin
      logic [DW-1:0] c;
      d = rnd_data(); c = d; c[k*SW +: SW] = CW;
      send(1'b0, c, xor_of(d));
    end
    // R4 parity chip flagged
    d = rnd_data();
    send(1'b0, d, CW);
    // R5 silent corruption
    d = rnd_data();
    begin
      logic [SW-1:0] p = xor_of(d);
      d[5*SW + 17] = ~d[5*SW + 17];
      send(1'b0, d, p);
    end
    // R6 two flagged data chips; a data chip plus the parity chip
    d = rnd_data(); begin
      logic [SW-1:0] p = xor_of(d);
      d[1*SW +: SW] = CW; d[6*SW +: SW] = CW;
      send(1'b0, d, p);
    end
    d = rnd_data(); d[2*SW +: SW] = CW;
    send(1'b0, d, CW);
    idle(3);

    // Random mix with output stalls (R7, R8)
    bp_en = 1'b1;
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 5);
      int k = $urandom_range(0, ND-1);
      logic [SW-1:0] p;
      d = rnd_data(); p = xor_of(d);
      case (kind)
        0: send(1'b1, d, p);
        1: send(1'b0, d, p);
        2: begin d[k*SW +: SW] = CW; send(1'b0, d, p); end
        3: send(1'b0, d, CW);
        4: begin d[k*SW] = ~d[k*SW]; send(1'b0, d, p); end
        default: begin d[k*SW +: SW] = CW; d[((k+1)%ND)*SW +: SW] = CW; send(1'b0, d, p); end
      endcase
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    bp_en = 1'b0;
    out_ready = 1'b1;
    idle(4);

    // R9 reset while a result is stalled
    out_ready = 1'b0;
    d = rnd_data();
    send(1'b0, d, xor_of(d));
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid after mid-run reset", DW'(out_valid), '0);
    chk(in_ready === 1'b1, "R9", "in_ready after mid-run reset", DW'(in_ready), DW'(1));
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule